// File: doc/BRIEF.md
# Paged-Counter I2C Target Front End

This block is the bus-facing half of a small I2C target. Its job is to turn serial traffic into byte strobes for a byte-addressed storage array. SCL and SDA arrive as raw levels and are resynchronised into the system clock. The block answers only to its own 7-bit address: the upper four bits are fixed by a parameter and the lower three come from strap inputs. It drives SDA through an open-drain enable.

A write transaction works as follows:
- The master addresses the block with the direction bit clear.
- The first byte after that loads an internal 8-bit address counter.
- Every later byte produces one write strobe at the counter.
- The counter then steps only inside its even-aligned two-byte page, so a third byte lands back on the even address of that page.

Reads start from wherever the counter currently points. Each byte fetched advances the counter modulo 256, and the counter keeps its value between transactions. A master that wants a read to begin at a chosen location first sends the memory address in a write, then issues a repeated start with the direction bit set.

The storage side can report that a nonvolatile commit is in progress. While it does, the block declines its own address, so a master can poll until the storage is ready.

Top module: `i2c_paged_target`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal `{4'b1010, strap_i[2:0]}`, sent MSB first. It drives SDA low during the ninth bit. The eighth bit selects the direction: 0 means write and 1 means read.
- R2: When the address byte does not match, SDA stays released and no write strobe or read request is issued until the next start condition.
- R3: In a write, the byte after the address byte loads the counter without producing a write strobe. Each later complete byte produces one `wr_en_o` pulse, with `mem_addr_o` equal to the counter and `wr_data_o` equal to that byte. Every data byte is acknowledged.
- R4: After each write strobe, the counter toggles its bit 0 and keeps bits 7:1. As a result, a third data byte overwrites the even address of the page, and a write that starts at an odd address continues at the even address below it.
- R5: Each byte read is preceded by one `rd_req_o` pulse with `mem_addr_o` set to the counter. The counter then increments modulo 256, and its value carries over to the next transaction. `rd_data_i` is sampled in the cycle after the request.
- R6: A master ACK (SDA low in the ninth bit) after a read byte causes the next byte to be fetched. A NACK releases SDA and raises no further request before the next start condition.
- R7: While `busy_i` is high at the end of the address byte, the address is not acknowledged and nothing is strobed.
- R8: SDA is sampled on rising SCL and read bits are shifted out MSB first. `sda_oe_o` changes only while SCL is low.
- R9: A start or stop condition in the middle of a byte aborts the transfer and discards the partial byte: no strobe is issued for it. A start condition restarts address reception.
- R10: While reset is asserted, and after it is released, `sda_oe_o`, `wr_en_o` and `rd_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL level from the pad |
| sda_i | input | 1 | Raw SDA level from the pad |
| strap_i | input | 3 | Low three bits of the target address |
| busy_i | input | 1 | Storage commit in progress; the address is refused |
| rd_data_i | input | 8 | Read byte, valid the cycle after `rd_req_o` |
| sda_oe_o | output | 1 | When high, the pad pulls SDA low |
| wr_en_o | output | 1 | One-cycle write strobe |
| wr_data_o | output | 8 | Byte to store |
| rd_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 8 | Storage address for the strobe or the request |

## Verification
On every cycle, the bound checker confirms four things:
- write strobes and read requests never coincide, and a write strobe never repeats in the following cycle;
- the counter after a write stays within the page of the strobed address, with bit 0 flipped;
- the counter after a read request is one above the requested address;
- the SDA enable changes only while SCL is low.

Only the bench scenarios can show the behaviours that span a whole transaction:
- address matching against the straps;
- the silence that follows a mismatch;
- refusal while busy;
- page wrap-around on a three-byte write;
- sequential reads across 0xFF into 0x00;
- the counter carrying over into a later current-address read;
- aborted partial bytes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_MEMADR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_MACK,
    ST_RLOAD,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_p, sda_p, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_p  <= scl_ff[STAGES-1];
      sda_p  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [3:0] DEV_ID    = 4'b1010,
  parameter int         PAGE_LOG2 = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic [BYTE_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] cnt_o
);
  tgt_state_e        state_q, state_d, ret_q, ret_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d, tx_q, tx_d, cnt_q, cnt_d;
  logic [BYTE_W-1:0] addr_q, addr_d, wdat_q, wdat_d;
  logic              oe_q, oe_d, ackph_q, ackph_d, wr_q, wr_d, rq_q, rq_d;
  logic [1:0]        ld_q, ld_d;
  logic [BYTE_W-1:0] byte_in, page_next;
  logic [PAGE_LOG2-1:0] low_inc;
  logic              dev_hit;

  assign byte_in   = {sh_q[BYTE_W-2:0], sda_s};
  assign dev_hit   = (byte_in[BYTE_W-1:1] == {DEV_ID, strap_i});
  assign low_inc   = cnt_q[PAGE_LOG2-1:0] + PAGE_LOG2'(1);
  assign page_next = {cnt_q[BYTE_W-1:PAGE_LOG2], low_inc};

  always_comb begin
    state_d = state_q;
    ret_d   = ret_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    tx_d    = ld_q[1] ? rd_data_i : tx_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    wdat_d  = wdat_q;
    oe_d    = oe_q;
    ackph_d = ackph_q;
    wr_d    = 1'b0;
    rq_d    = 1'b0;
    ld_d    = {ld_q[0], 1'b0};
    if (start_det) begin
      state_d = ST_DEVADR;
      bit_d   = '0;
      oe_d    = 1'b0;
      ackph_d = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_DEVADR, ST_MEMADR, ST_WDATA: begin
          if (scl_rise) begin
            sh_d  = byte_in;
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) begin
              state_d = ST_ACK;
              ackph_d = 1'b0;
              ret_d   = ST_WDATA;
              if (state_q == ST_DEVADR) begin
                if (dev_hit && !busy_i) begin
                  ret_d = byte_in[0] ? ST_RDATA : ST_MEMADR;
                  if (byte_in[0]) begin
                    rq_d    = 1'b1;
                    addr_d  = cnt_q;
                    cnt_d   = cnt_q + 8'd1;
                    ld_d[0] = 1'b1;
                  end
                end else begin
                  state_d = ST_SKIP;
                end
              end else if (state_q == ST_MEMADR) begin
                cnt_d = byte_in;
              end else begin
                wr_d   = 1'b1;
                addr_d = cnt_q;
                wdat_d = byte_in;
                cnt_d  = page_next;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            if (!ackph_q) begin
              oe_d    = 1'b1;
              ackph_d = 1'b1;
            end else begin
              ackph_d = 1'b0;
              bit_d   = '0;
              state_d = ret_q;
              oe_d    = (ret_q == ST_RDATA) ? ~tx_q[BYTE_W-1] : 1'b0;
            end
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bit_d = bit_q + 3'd1;
            if (bit_q == 3'd7) state_d = ST_MACK;
          end else if (scl_fall) begin
            oe_d = ~tx_q[BYTE_W-2];
            tx_d = {tx_q[BYTE_W-2:0], 1'b0};
          end
        end
        ST_MACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
          end else if (scl_rise) begin
            if (!sda_s) begin
              rq_d    = 1'b1;
              addr_d  = cnt_q;
              cnt_d   = cnt_q + 8'd1;
              ld_d[0] = 1'b1;
              state_d = ST_RLOAD;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_RLOAD: begin
          if (scl_fall) begin
            oe_d    = ~tx_q[BYTE_W-1];
            bit_d   = '0;
            state_d = ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ret_q   <= ST_IDLE;
      bit_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      oe_q    <= 1'b0;
      ackph_q <= 1'b0;
      wr_q    <= 1'b0;
      rq_q    <= 1'b0;
      ld_q    <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      wdat_q  <= wdat_d;
      oe_q    <= oe_d;
      ackph_q <= ackph_d;
      wr_q    <= wr_d;
      rq_q    <= rq_d;
      ld_q    <= ld_d;
    end
  end

  assign sda_oe_o   = oe_q;
  assign wr_en_o    = wr_q;
  assign wr_data_o  = wdat_q;
  assign rd_req_o   = rq_q;
  assign mem_addr_o = addr_q;
  assign cnt_o      = cnt_q;
endmodule

// File: rtl/i2c_paged_target.sv
module i2c_paged_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [3:0] DEV_ID      = 4'b1010,
  parameter int         PAGE_LOG2   = 1,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  input  logic [BYTE_W-1:0] rd_data_i,
  output logic              sda_oe_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              rd_req_o,
  output logic [BYTE_W-1:0] mem_addr_o
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [BYTE_W-1:0] addr_cnt;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_fsm #(.DEV_ID(DEV_ID), .PAGE_LOG2(PAGE_LOG2)) i_fsm (
    .clk(clk), .rst_n(rst_n), .strap_i(strap_i), .busy_i(busy_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .rd_data_i(rd_data_i),
    .sda_oe_o(sda_oe_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
    .rd_req_o(rd_req_o), .mem_addr_o(mem_addr_o), .cnt_o(addr_cnt)
  );
endmodule

// File: rtl/i2c_paged_target_chk.sv
module i2c_paged_target_chk #(
  parameter int PAGE_LOG2 = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_oe,
  input logic       wr_en,
  input logic       rd_req,
  input logic [7:0] mem_addr,
  input logic [7:0] cnt
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && rd_req)) else $error("strobe overlap"); // R5
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en) else $error("write strobe repeated"); // R3
  AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (cnt[7:PAGE_LOG2] == mem_addr[7:PAGE_LOG2]) &&
              (cnt[PAGE_LOG2-1:0] == mem_addr[PAGE_LOG2-1:0] + PAGE_LOG2'(1)))
    else $error("counter left page"); // R4
  AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (cnt == mem_addr + 8'd1)) else $error("read step wrong"); // R5
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i) else $error("sda moved with scl high"); // R8
endmodule

bind i2c_paged_target i2c_paged_target_chk #(.PAGE_LOG2(PAGE_LOG2)) i_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe_o),
  .wr_en(wr_en_o), .rd_req(rd_req_o), .mem_addr(mem_addr_o), .cnt(addr_cnt)
);

// File: tb/test_i2c_paged_target.sv
module test_i2c_paged_target;
  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m, busy;
  logic [2:0] strap;
  logic [7:0] rd_data, wr_data, mem_addr;
  logic sda_oe, wr_en, rd_req;
  logic sda_bus;
  logic [7:0] mem [256];
  int wr_cnt = 0, rd_cnt = 0;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_paged_target i_i2c_paged_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .strap_i(strap), .busy_i(busy), .rd_data_i(rd_data),
    .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .rd_req_o(rd_req), .mem_addr_o(mem_addr)
  );

  always @(posedge clk) begin
    if (wr_en) begin mem[mem_addr] <= wr_data; wr_cnt <= wr_cnt + 1; end
    if (rd_req) begin rd_data <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
  end

  localparam logic [7:0] DEV_W = 8'hA6;
  localparam logic [7:0] DEV_R = 8'hA7;
  localparam int NV = 6;
  localparam logic [15:0] VEC [NV] = '{16'h003C, 16'h01C3, 16'h7E81,
                                       16'hF80F, 16'hFAF0, 16'hFF5A};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q(); repeat (6) @(negedge clk); endtask

  task automatic bus_start();
    q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    q(); sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic tx_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      q(); sda_m = b[i]; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0;
    end
  endtask

  task automatic tx_byte(input logic [7:0] b, output logic ack);
    tx_bits(b, 8);
    q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = sda_bus; q(); scl_m = 1'b0;
  endtask

  task automatic rx_byte(input bit give_ack, output logic [7:0] b);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      q(); sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = {b[6:0], sda_bus}; q(); scl_m = 1'b0;
    end
    q(); sda_m = give_ack ? 1'b0 : 1'b1; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0;
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d, input string req);
    logic k;
    bus_start();
    tx_byte(DEV_W, k); chk({req, " dev ack"}, k, 0);
    tx_byte(a, k);     chk({req, " maddr ack"}, k, 0);
    tx_byte(d, k);     chk({req, " data ack"}, k, 0);
    bus_stop();
  endtask

  task automatic rd_at(input logic [7:0] a, output logic [7:0] d);
    logic k;
    bus_start(); tx_byte(DEV_W, k); tx_byte(a, k);
    bus_start(); tx_byte(DEV_R, k); chk("R1 read dev ack", k, 0);
    rx_byte(0, d);
    bus_stop();
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    logic k;
    logic [7:0] d;
    int w0, r0;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0; strap = 3'b011;
    repeat (5) @(negedge clk);
    chk("R10 oe in reset", sda_oe, 0);
    chk("R10 wr in reset", wr_en, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 oe after reset", sda_oe, 0);
    chk("R10 rd after reset", rd_req, 0);

    // R1 R3 R5: vector table of single writes, read back
    for (int v = 0; v < NV; v++) begin
      wr1(VEC[v][15:8], VEC[v][7:0], "R3");
      rd_at(VEC[v][15:8], d);
      chk("R5 readback", d, VEC[v][7:0]);
    end

    // R5 R6: sequential read across FF->00, then current-address read
    bus_start(); tx_byte(DEV_W, k); tx_byte(8'hFF, k);
    r0 = rd_cnt;
    bus_start(); tx_byte(DEV_R, k);
    rx_byte(1, d); chk("R5 seq byte FF", d, 8'h5A);
    rx_byte(0, d); chk("R5 seq byte 00 wrap", d, 8'h3C);
    bus_stop();
    chk("R6 requests for two bytes", rd_cnt - r0, 2);
    bus_start(); tx_byte(DEV_R, k); rx_byte(0, d); bus_stop();
    chk("R5 counter persisted to 01", d, 8'hC3);

    // R2: foreign address ignored
    w0 = wr_cnt;
    bus_start(); tx_byte(8'hA0, k); chk("R2 foreign nack", k, 1);
    tx_byte(8'h40, k); chk("R2 no ack later", k, 1);
    tx_byte(8'h99, k); bus_stop();
    chk("R2 no write strobes", wr_cnt - w0, 0);

    // R4: three bytes at even page, two at odd
    bus_start(); tx_byte(DEV_W, k); tx_byte(8'h10, k);
    tx_byte(8'h11, k); tx_byte(8'h22, k); tx_byte(8'h33, k); bus_stop();
    rd_at(8'h10, d); chk("R4 wrap overwrote even", d, 8'h33);
    rd_at(8'h11, d); chk("R4 odd kept", d, 8'h22);
    bus_start(); tx_byte(DEV_W, k); tx_byte(8'h21, k);
    tx_byte(8'h44, k); tx_byte(8'h55, k); bus_stop();
    rd_at(8'h21, d); chk("R4 odd start", d, 8'h44);
    rd_at(8'h20, d); chk("R4 odd start wraps to even", d, 8'h55);

    // R7: busy refuses address
    busy = 1'b1; w0 = wr_cnt;
    bus_start(); tx_byte(DEV_W, k); chk("R7 busy nack", k, 1);
    tx_byte(8'h00, k); tx_byte(8'hEE, k); bus_stop();
    chk("R7 nothing written", wr_cnt - w0, 0);
    busy = 1'b0;
    bus_start(); tx_byte(DEV_W, k); chk("R7 ack once idle", k, 0); bus_stop();

    // R9: stop and start mid-byte
    w0 = wr_cnt;
    bus_start(); tx_byte(DEV_W, k); tx_byte(8'h30, k); tx_bits(8'hAB, 4); bus_stop();
    chk("R9 stop discards partial", wr_cnt - w0, 0);
    bus_start(); tx_byte(DEV_W, k); tx_byte(8'h30, k); tx_bits(8'hCD, 3);
    bus_start(); tx_byte(DEV_W, k); chk("R9 restart ack", k, 0);
    tx_byte(8'h31, k); tx_byte(8'h77, k); bus_stop();
    chk("R9 one strobe only", wr_cnt - w0, 1);
    rd_at(8'h31, d); chk("R9 restarted write", d, 8'h77);
    chk("R8 released at idle", sda_oe, 0);

    done = 1;
    summary();
  end
endmodule